// File: doc/BRIEF.md
# Audio Codec Link Input Frame Receiver

This block takes the serial return stream of an audio codec link and turns it into control information for the rest of the audio path. It watches the bit clock, the frame-sync line and the serial data line, all sampled with the system clock. It finds each frame from the rising edge of the sync line and cuts the frame into a 16-bit tag slot and twelve 20-bit data slots. Each field is shifted in most significant bit first, and each bit is taken on a falling edge of the bit clock.

From the tag slot the block reports whether the codec is ready and which data slots carry valid content. Slot 1 carries the echoed register index and the active-low request flags that tell the output frame builder which output slots need a sample in the next frame. A read command issued by the controller leaves a pending index. A status word from slot 2 is delivered, as a one-cycle strobe, only when the frame marks slots 1 and 2 valid and the echoed index equals the pending one. Any other return is dropped.

Top module: `acrx_input_frame`

## Requirements
- R1: After reset, codec_ready is 0, slot_valid is all zeros, slot_req_n is all ones, rd_busy is 0 and stat_vld is 0.
- R2: A frame starts at the falling bit-clock edge where link_sync is sampled 1 after being sampled 0 at the previous falling edge. The frame is 16 tag bits followed by twelve 20-bit slots, MSB first. Bits that arrive outside a frame are ignored. A new sync rising edge restarts framing, even in the middle of a frame.
- R3: codec_ready takes tag bit 15 of the current frame when slot 1 completes. It holds that value until slot 1 of a later frame completes.
- R4: slot_valid[i] takes tag bit 14-i, the valid flag of data slot i+1, when the tag slot completes.
- R5: slot_req_n[i] takes slot 1 bit 11-i, the active-low request for output slot i+3, when slot 1 completes. Bit 11 requests slot 3 and bit 2 requests slot 12. The vector holds at all other times.
- R6: A pulse on rd_issue stores rd_addr as the pending index and sets rd_busy on the next cycle.
- R7: When slot 2 completes, a status word is accepted if all of these hold: tag bits 14 and 13 were 1, rd_busy is 1, and slot 1 bits 18:12 equal the pending index. On acceptance, stat_vld pulses for one cycle, stat_data carries slot 2 bits 19:4, stat_addr carries the index, and rd_busy clears.
- R8: A return whose index differs from the pending index produces no strobe, and rd_busy stays 1.
- R9: A return whose tag marks slot 1 or slot 2 invalid produces no strobe, even when the index matches. rd_busy stays 1.
- R10: With no pending read, slot 2 produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_bclk | input | 1 | Link bit clock, sampled by clk |
| link_sync | input | 1 | Frame sync from the controller side |
| link_sdin | input | 1 | Serial data from the codec |
| rd_issue | input | 1 | One-cycle pulse when a register read command is sent |
| rd_addr | input | 7 | Register index of that read |
| codec_ready | output | 1 | Codec-ready flag of the latest frame |
| slot_valid | output | 12 | Valid flags, bit i for data slot i+1 |
| slot_req_n | output | 10 | Active-low requests, bit i for output slot i+3 |
| rd_busy | output | 1 | A read is waiting for its status |
| stat_vld | output | 1 | One-cycle strobe for accepted status |
| stat_addr | output | 7 | Index of the accepted status |
| stat_data | output | 16 | Accepted status word |

## Verification
A bit is taken on the first clk edge at which the bit clock is seen low after being high. The slot it completes is announced one cycle later. The register outputs and the status strobe follow one further cycle after that, so each result is due two clk cycles after the falling edge of the last bit of its slot. Each bit period in the bench lasts four clk cycles. Every check is made at a negative clk edge and only after at least one further bit period has passed, so the value is settled when it is sampled. The one-cycle status strobe is caught by a monitor that counts pulses and latches their address and data, and the scenario tasks compare against counts taken before each frame.

// File: rtl/acrx_pkg.sv
package acrx_pkg;

    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;
    localparam int IDX_BITS   = 7;
    localparam int STAT_BITS  = 16;
    localparam int REQ_SLOTS  = 10;
    localparam int SLOT_ID_W  = $clog2(DATA_SLOTS + 1);
    localparam int CNT_W      = $clog2(SLOT_BITS + 1);

    typedef logic [SLOT_BITS-1:0] slot_word_t;
    typedef logic [SLOT_ID_W-1:0] slot_id_t;

    localparam slot_id_t SLOT_TAG  = slot_id_t'(0);
    localparam slot_id_t SLOT_ADDR = slot_id_t'(1);
    localparam slot_id_t SLOT_STAT = slot_id_t'(2);
    localparam slot_id_t SLOT_LAST = slot_id_t'(DATA_SLOTS);

    // tag slot layout, MSB first
    typedef struct packed {
        logic                  ready;
        logic [DATA_SLOTS-1:0] valid;  // [DATA_SLOTS-1] = slot 1
        logic [2:0]            spare;
    } tag_t;

    // slot 1 layout, MSB first
    typedef struct packed {
        logic                 rsvd;
        logic [IDX_BITS-1:0]  idx;
        logic [REQ_SLOTS-1:0] req;    // [REQ_SLOTS-1] = output slot 3
        logic [1:0]           low;
    } addr_slot_t;

    typedef struct packed {
        logic       done;
        slot_id_t   id;
        slot_word_t word;
    } slot_evt_t;

    function automatic logic [DATA_SLOTS-1:0] order_valid(input logic [DATA_SLOTS-1:0] f);
        for (int i = 0; i < DATA_SLOTS; i++) order_valid[i] = f[DATA_SLOTS-1-i];
    endfunction

    function automatic logic [REQ_SLOTS-1:0] order_req(input logic [REQ_SLOTS-1:0] f);
        for (int i = 0; i < REQ_SLOTS; i++) order_req[i] = f[REQ_SLOTS-1-i];
    endfunction

endpackage

// File: rtl/acrx_bit_sampler.sv
module acrx_bit_sampler (
    input  logic clk,
    input  logic rst,
    input  logic link_bclk,
    input  logic link_sync,
    input  logic link_sdin,
    output logic bit_vld,
    output logic bit_val,
    output logic frame_start
);
    logic bclk_q;
    logic sync_q;

    assign bit_vld     = bclk_q & ~link_bclk;
    assign bit_val     = link_sdin;
    assign frame_start = bit_vld & link_sync & ~sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            bclk_q <= link_bclk;
            if (bit_vld) sync_q <= link_sync;
        end
    end

    // R2: one falling edge cannot be taken twice
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld);

endmodule

// File: rtl/acrx_slot_framer.sv
module acrx_slot_framer
    import acrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_vld,
    input  logic      bit_val,
    input  logic      frame_start,
    output slot_evt_t evt
);
    logic              in_frame;
    slot_id_t          slot_no;
    logic [CNT_W-1:0]  left;
    slot_word_t        shreg;
    slot_word_t        shifted;

    assign shifted = {shreg[SLOT_BITS-2:0], bit_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            slot_no  <= SLOT_TAG;
            left     <= '0;
            shreg    <= '0;
            evt      <= '0;
        end else begin
            evt.done <= 1'b0;
            if (bit_vld && frame_start) begin
                in_frame <= 1'b1;
                slot_no  <= SLOT_TAG;
                left     <= CNT_W'(TAG_BITS - 1);
                shreg    <= {{(SLOT_BITS-1){1'b0}}, bit_val};
            end else if (bit_vld && in_frame) begin
                shreg <= shifted;
                if (left == CNT_W'(1)) begin
                    evt.done <= 1'b1;
                    evt.id   <= slot_no;
                    evt.word <= shifted;
                    left     <= CNT_W'(SLOT_BITS);
                    if (slot_no == SLOT_LAST) in_frame <= 1'b0;
                    else slot_no <= slot_id_t'(slot_no + 1'b1);
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

    // R2: slot numbers stay inside the frame
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        evt.done |-> evt.id <= SLOT_LAST);

    // R2: bit counter never leaves its window while framing
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_frame |-> (left != '0) && (left <= CNT_W'(SLOT_BITS)));

endmodule

// File: rtl/acrx_status_decoder.sv
module acrx_status_decoder
    import acrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  slot_evt_t             evt,
    input  logic                  rd_issue,
    input  logic [IDX_BITS-1:0]   rd_addr,
    output logic                  codec_ready,
    output logic [DATA_SLOTS-1:0] slot_valid,
    output logic [REQ_SLOTS-1:0]  slot_req_n,
    output logic                  rd_busy,
    output logic                  stat_vld,
    output logic [IDX_BITS-1:0]   stat_addr,
    output logic [STAT_BITS-1:0]  stat_data
);
    tag_t                tag_in;
    addr_slot_t          s1_in;
    logic                ready_r;
    logic                s1_ok_r;
    logic                s2_ok_r;
    logic [IDX_BITS-1:0] idx_r;
    logic [IDX_BITS-1:0] pend_addr;
    logic                tag_done;
    logic                addr_done;
    logic                accept;
    logic                unused_fields;

    assign tag_in    = evt.word[TAG_BITS-1:0];
    assign s1_in     = evt.word;
    assign tag_done  = evt.done && (evt.id == SLOT_TAG);
    assign addr_done = evt.done && (evt.id == SLOT_ADDR);
    assign accept    = evt.done && (evt.id == SLOT_STAT) && s1_ok_r && s2_ok_r
                       && rd_busy && (idx_r == pend_addr);
    assign unused_fields = ^{tag_in.spare, s1_in.rsvd, s1_in.low};

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_r     <= 1'b0;
            s1_ok_r     <= 1'b0;
            s2_ok_r     <= 1'b0;
            idx_r       <= '0;
            pend_addr   <= '0;
            codec_ready <= 1'b0;
            slot_valid  <= '0;
            slot_req_n  <= '1;
            rd_busy     <= 1'b0;
            stat_vld    <= 1'b0;
            stat_addr   <= '0;
            stat_data   <= '0;
        end else begin
            stat_vld <= accept;
            if (accept) begin
                stat_addr <= pend_addr;
                stat_data <= evt.word[SLOT_BITS-1 -: STAT_BITS];
            end
            if (tag_done) begin
                ready_r    <= tag_in.ready;
                s1_ok_r    <= tag_in.valid[DATA_SLOTS-1];
                s2_ok_r    <= tag_in.valid[DATA_SLOTS-2];
                slot_valid <= order_valid(tag_in.valid);
            end
            if (addr_done) begin
                idx_r       <= s1_in.idx;
                codec_ready <= ready_r;
                slot_req_n  <= order_req(s1_in.req);
            end
            if (rd_issue) begin
                rd_busy   <= 1'b1;
                pend_addr <= rd_addr;
            end else if (accept) begin
                rd_busy <= 1'b0;
            end
        end
    end

    // R7
    stat_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> $past(rd_busy));

    // R7
    stat_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_vld && !$past(rd_issue)) |-> !rd_busy);

    // R6
    issue_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_issue |=> rd_busy);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(addr_done) |-> $stable(slot_req_n));

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(addr_done) |-> $stable(codec_ready));

endmodule

// File: rtl/acrx_input_frame.sv
module acrx_input_frame
    import acrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  link_bclk,
    input  logic                  link_sync,
    input  logic                  link_sdin,
    input  logic                  rd_issue,
    input  logic [IDX_BITS-1:0]   rd_addr,
    output logic                  codec_ready,
    output logic [DATA_SLOTS-1:0] slot_valid,
    output logic [REQ_SLOTS-1:0]  slot_req_n,
    output logic                  rd_busy,
    output logic                  stat_vld,
    output logic [IDX_BITS-1:0]   stat_addr,
    output logic [STAT_BITS-1:0]  stat_data
);
    logic      bit_vld;
    logic      bit_val;
    logic      frame_start;
    slot_evt_t evt;

    acrx_bit_sampler u_sampler (
        .clk         (clk),
        .rst         (rst),
        .link_bclk   (link_bclk),
        .link_sync   (link_sync),
        .link_sdin   (link_sdin),
        .bit_vld     (bit_vld),
        .bit_val     (bit_val),
        .frame_start (frame_start)
    );

    acrx_slot_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (bit_vld),
        .bit_val     (bit_val),
        .frame_start (frame_start),
        .evt         (evt)
    );

    acrx_status_decoder u_decoder (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rd_issue    (rd_issue),
        .rd_addr     (rd_addr),
        .codec_ready (codec_ready),
        .slot_valid  (slot_valid),
        .slot_req_n  (slot_req_n),
        .rd_busy     (rd_busy),
        .stat_vld    (stat_vld),
        .stat_addr   (stat_addr),
        .stat_data   (stat_data)
    );

endmodule

// File: tb/tb_acrx_input_frame.sv
module tb_acrx_input_frame;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_bclk = 1'b0;
    logic        link_sync = 1'b0;
    logic        link_sdin = 1'b0;
    logic        rd_issue = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        codec_ready;
    logic [11:0] slot_valid;
    logic [9:0]  slot_req_n;
    logic        rd_busy;
    logic        stat_vld;
    logic [6:0]  stat_addr;
    logic [15:0] stat_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int          pulse_cnt = 0;
    logic [15:0] pulse_data = '0;
    logic [6:0]  pulse_addr = '0;

    always #10 clk = ~clk;

    acrx_input_frame dut (
        .clk(clk), .rst(rst),
        .link_bclk(link_bclk), .link_sync(link_sync), .link_sdin(link_sdin),
        .rd_issue(rd_issue), .rd_addr(rd_addr),
        .codec_ready(codec_ready), .slot_valid(slot_valid), .slot_req_n(slot_req_n),
        .rd_busy(rd_busy), .stat_vld(stat_vld), .stat_addr(stat_addr), .stat_data(stat_data)
    );

    always @(posedge clk) begin
        if (!rst && stat_vld) begin
            pulse_cnt  <= pulse_cnt + 1;
            pulse_data <= stat_data;
            pulse_addr <= stat_addr;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_tag(input logic rdy, input logic [11:0] v);
        return {rdy, v, 3'b000};
    endfunction

    function automatic logic [19:0] mk_s1(input logic [6:0] idx, input logic [9:0] req);
        return {1'b0, idx, req, 2'b00};
    endfunction

    function automatic logic [11:0] exp_valid(input logic [15:0] tag);
        logic [11:0] e;
        for (int i = 0; i < 12; i++) e[i] = tag[14-i];
        return e;
    endfunction

    function automatic logic [9:0] exp_req(input logic [19:0] s1);
        logic [9:0] e;
        for (int i = 0; i < 10; i++) e[i] = s1[11-i];
        return e;
    endfunction

    task automatic send_bit(input logic s, input logic d);
        @(negedge clk); link_bclk = 1'b1; link_sync = s; link_sdin = d;
        @(negedge clk);
        @(negedge clk); link_bclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1,
                              input logic [19:0] s2, input int nbits);
        logic [255:0] fr;
        fr = {tag, s1, s2, 200'h0};
        for (int k = 0; k < nbits; k++) send_bit(k < 16, fr[255-k]);
    endtask

    task automatic issue_read(input logic [6:0] a);
        @(negedge clk); rd_issue = 1'b1; rd_addr = a;
        @(negedge clk); rd_issue = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "codec_ready", 32'(codec_ready), 32'd0);
        check("R1", "slot_valid", 32'(slot_valid), 32'd0);
        check("R1", "slot_req_n", 32'(slot_req_n), 32'h3FF);
        check("R1", "rd_busy", 32'(rd_busy), 32'd0);
        check("R1", "stat_vld", 32'(stat_vld), 32'd0);
    endtask

    task automatic t_fixed_rate;
        logic [15:0] tg;
        int p0;
        tg = mk_tag(1'b1, 12'hFFF);
        p0 = pulse_cnt;
        send_frame(tg, mk_s1(7'h00, 10'h000), 20'h0, 256);
        check("R3", "ready set", 32'(codec_ready), 32'd1);
        check("R4", "all valid", 32'(slot_valid), 32'(exp_valid(tg)));
        check("R5", "all requests low", 32'(slot_req_n), 32'd0);
        check("R10", "no strobe without read", 32'(pulse_cnt - p0), 32'd0);
    endtask

    task automatic t_variable;
        logic [15:0] tg;
        logic [19:0] s1;
        tg = mk_tag(1'b0, 12'b1010_0110_0001);
        s1 = mk_s1(7'h00, 10'b0110101100);
        send_frame(tg, s1, 20'h0, 256);
        check("R3", "ready cleared", 32'(codec_ready), 32'd0);
        check("R4", "valid pattern", 32'(slot_valid), 32'(exp_valid(tg)));
        check("R5", "request order", 32'(slot_req_n), 32'(exp_req(s1)));
    endtask

    task automatic t_hold_and_resync;
        logic [15:0] tg;
        logic [19:0] s1;
        logic [9:0]  old_req;
        old_req = slot_req_n;
        tg = mk_tag(1'b1, 12'h3C5);
        s1 = mk_s1(7'h00, 10'b1100000011);
        send_frame(tg, s1, 20'h0, 31);
        check("R4", "tags after tag slot", 32'(slot_valid), 32'(exp_valid(tg)));
        check("R3", "ready held mid slot 1", 32'(codec_ready), 32'd0);
        check("R5", "requests held mid slot 1", 32'(slot_req_n), 32'(old_req));
        send_frame(tg, s1, 20'h0, 256);
        check("R2", "resync ready", 32'(codec_ready), 32'd1);
        check("R2", "resync requests", 32'(slot_req_n), 32'(exp_req(s1)));
    endtask

    task automatic t_idle_ignored;
        logic [11:0] v0;
        logic [9:0]  r0;
        v0 = slot_valid;
        r0 = slot_req_n;
        for (int k = 0; k < 60; k++) send_bit(1'b0, 1'b0);
        check("R2", "idle valid unchanged", 32'(slot_valid), 32'(v0));
        check("R2", "idle requests unchanged", 32'(slot_req_n), 32'(r0));
        check("R2", "idle ready unchanged", 32'(codec_ready), 32'd1);
    endtask

    task automatic t_read_match;
        int p0;
        issue_read(7'h2A);
        check("R6", "busy after issue", 32'(rd_busy), 32'd1);
        p0 = pulse_cnt;
        send_frame(mk_tag(1'b1, 12'hC00), mk_s1(7'h2A, 10'h3FF), {16'hBEEF, 4'h0}, 256);
        check("R7", "one strobe", 32'(pulse_cnt - p0), 32'd1);
        check("R7", "status data", 32'(pulse_data), 32'hBEEF);
        check("R7", "status addr", 32'(pulse_addr), 32'h2A);
        check("R7", "busy cleared", 32'(rd_busy), 32'd0);
    endtask

    task automatic t_mismatch;
        int p0;
        issue_read(7'h11);
        p0 = pulse_cnt;
        send_frame(mk_tag(1'b1, 12'hC00), mk_s1(7'h12, 10'h3FF), {16'h5555, 4'h0}, 256);
        check("R8", "no strobe on mismatch", 32'(pulse_cnt - p0), 32'd0);
        check("R8", "busy kept", 32'(rd_busy), 32'd1);
        send_frame(mk_tag(1'b1, 12'hC00), mk_s1(7'h11, 10'h3FF), {16'h1234, 4'h0}, 256);
        check("R7", "strobe on later match", 32'(pulse_cnt - p0), 32'd1);
        check("R7", "later data", 32'(pulse_data), 32'h1234);
    endtask

    task automatic t_tag_invalid;
        int p0;
        issue_read(7'h05);
        p0 = pulse_cnt;
        send_frame(mk_tag(1'b1, 12'h800), mk_s1(7'h05, 10'h3FF), {16'hAAAA, 4'h0}, 256);
        check("R9", "slot 2 invalid", 32'(pulse_cnt - p0), 32'd0);
        send_frame(mk_tag(1'b1, 12'h400), mk_s1(7'h05, 10'h3FF), {16'hAAAA, 4'h0}, 256);
        check("R9", "slot 1 invalid", 32'(pulse_cnt - p0), 32'd0);
        check("R9", "busy kept", 32'(rd_busy), 32'd1);
        send_frame(mk_tag(1'b1, 12'hC00), mk_s1(7'h05, 10'h3FF), {16'h0F0F, 4'h0}, 256);
        check("R7", "match after invalid", 32'(pulse_data), 32'h0F0F);
    endtask

    task automatic t_no_pending;
        int p0;
        p0 = pulse_cnt;
        send_frame(mk_tag(1'b1, 12'hC00), mk_s1(7'h05, 10'h3FF), {16'h7777, 4'h0}, 256);
        check("R10", "no strobe after clear", 32'(pulse_cnt - p0), 32'd0);
        check("R10", "busy stays low", 32'(rd_busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed_rate();
        t_variable();
        t_hold_and_resync();
        t_idle_ignored();
        t_read_match();
        t_mismatch();
        t_tag_invalid();
        t_no_pending();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule